// File: doc/BRIEF.md
# Pulsed Command Dispatcher

This block sits behind a simple register write port. Software writes a 16-bit word, and the block turns that word into a single-cycle strobe on exactly one of nine command outputs. Those outputs drive processor data transfers, shared-memory row transfers, the memory self-test launcher, the idle-color reset, control-packet transmission and the two control-packet queue operations. Nothing is stored: the register reads back as zero, and software never has to clear it.

Three rules govern whether a write is accepted. A word that carries more than one command bit is refused as a whole and sets a sticky error flag. The self-test launch is honoured only while the device is in standby and no traffic has run since the last power-on or flush reset; in any other case that bit is dropped without comment. The reserved bits are never looked at. A small state machine classifies every write as IDLE (no write), FIRE (one legal command), REJECT (several commands) or DROP (no command left after gating). The strobe and the error flag are driven from registers.

Top module: `cmd_pulse_dispatch`

## Requirements
- R1: A write with one legal command sets that command's output high in the clock cycle that follows the write edge, for exactly one cycle. A cycle with no write produces no strobe.
- R2: Bits are numbered MSB-first, so register bit k is `wdata[15-k]`. The command map is: bit 7 (`wdata[8]`) processor write, bit 8 (`wdata[7]`) processor read, bit 9 (`wdata[6]`) self-test start, bit 10 (`wdata[5]`) color clear, bit 11 (`wdata[4]`) row write, bit 12 (`wdata[3]`) row read, bit 13 (`wdata[2]`) control-packet transmit, bit 14 (`wdata[1]`) queue load, bit 15 (`wdata[0]`) queue free.
- R3: Reserved bits 0..6 (`wdata[15:9]`) have no effect on any output.
- R4: A write with two or more of `wdata[8:0]` set produces no strobe at all. `err_multi` goes high in the next cycle and stays high until reset.
- R5: Self-test start strobes only when `standby` and `fresh_reset` are both high at the write edge. Otherwise the bit is ignored: no strobe and no error.
- R6: After reset every strobe and `err_multi` are low.
- R7: `rdata` always reads zero.
- R8: Writes on consecutive cycles each produce their own strobe, one cycle after each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, always zero |
| standby | input | 1 | Device is in standby mode |
| fresh_reset | input | 1 | No traffic since the last power-on or flush reset |
| go_proc_wr | output | 1 | Processor write strobe |
| go_proc_rd | output | 1 | Processor read strobe |
| go_selftest | output | 1 | Memory self-test start strobe |
| go_color_clr | output | 1 | Idle color state clear strobe |
| go_row_wr | output | 1 | Shared-memory row write strobe |
| go_row_rd | output | 1 | Shared-memory row read strobe |
| go_ctl_tx | output | 1 | Control-packet transmit strobe |
| go_q_load | output | 1 | Load head-of-queue address strobe |
| go_q_free | output | 1 | Free head-of-queue address strobe |
| err_multi | output | 1 | Sticky flag: a multi-command write was rejected |

## Verification
The bench walks a single bit across all nine command positions. A design that numbered the bits LSB-first, or shifted the map by one, would raise the wrong strobe. It sets the reserved bits both on their own and alongside a command, so a decoder that counted them as commands would either strobe or reject those writes. Self-test writes are issued under every combination of the two mode inputs, and self-test is also paired with a second command: a design that gated too late would fire in the wrong mode, and one that gated too early would fire the other command instead of rejecting the pair. Back-to-back writes and random words, modelled by a bench function, expose any strobe that lasts two cycles, any dropped strobe, and an error flag that clears on its own.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    localparam int DATA_W   = 16;
    localparam int CMD_BASE = 7;
    localparam int NUM_CMD  = 9;
    localparam int ST_IDX   = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRE,
        ST_REJECT,
        ST_DROP
    } seq_state_e;
endpackage

// File: rtl/cmdreg_field_decode.sv
module cmdreg_field_decode #(
    parameter int DATA_W   = 16,
    parameter int CMD_BASE = 7,
    parameter int NUM_CMD  = 9
) (
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_CMD-1:0] cmd_vec,
    output logic               multi
);
    localparam int CMD_MSB = DATA_W - 1 - CMD_BASE;
    localparam int CNT_W   = $clog2(NUM_CMD + 1);

    // command j sits at MSB-first position CMD_BASE+j
    for (genvar j = 0; j < NUM_CMD; j++) begin : g_map
        assign cmd_vec[j] = wdata[CMD_MSB - j];
    end

    logic [CNT_W-1:0] ones;
    always_comb begin
        ones = '0;
        for (int j = 0; j < NUM_CMD; j++) begin
            ones = ones + CNT_W'(cmd_vec[j]);
        end
    end

    assign multi = (ones > CNT_W'(1));
endmodule

// File: rtl/cmdreg_mode_gate.sv
module cmdreg_mode_gate #(
    parameter int NUM_CMD = 9,
    parameter int ST_IDX  = 2
) (
    input  logic [NUM_CMD-1:0] cmd_in,
    input  logic               standby,
    input  logic               fresh_reset,
    output logic [NUM_CMD-1:0] cmd_out
);
    logic st_ok;
    assign st_ok = standby & fresh_reset;

    for (genvar j = 0; j < NUM_CMD; j++) begin : g_gate
        if (j == ST_IDX) begin : g_st
            assign cmd_out[j] = cmd_in[j] & st_ok;
        end else begin : g_pass
            assign cmd_out[j] = cmd_in[j];
        end
    end
endmodule

// File: rtl/cmdreg_seq.sv
module cmdreg_seq
    import cmdreg_pkg::*;
#(
    parameter int NUM_CMD = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_CMD-1:0] cmd,
    input  logic               multi,
    output logic [NUM_CMD-1:0] pulse_q,
    output logic               err_q,
    output seq_state_e         state_q
);
    seq_state_e state_d;

    // classify the current bus cycle
    always_comb begin
        if (!wr_en) begin
            state_d = ST_IDLE;
        end else if (multi) begin
            state_d = ST_REJECT;
        end else if (cmd == '0) begin
            state_d = ST_DROP;
        end else begin
            state_d = ST_FIRE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_d)
                ST_FIRE: begin
                    pulse_q <= cmd;
                end
                ST_REJECT: begin
                    pulse_q <= '0;
                    err_q   <= 1'b1;
                end
                ST_IDLE, ST_DROP: begin
                    pulse_q <= '0;
                end
                default: begin
                    pulse_q <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/cmd_pulse_dispatch.sv
module cmd_pulse_dispatch
    import cmdreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              standby,
    input  logic              fresh_reset,
    output logic              go_proc_wr,
    output logic              go_proc_rd,
    output logic              go_selftest,
    output logic              go_color_clr,
    output logic              go_row_wr,
    output logic              go_row_rd,
    output logic              go_ctl_tx,
    output logic              go_q_load,
    output logic              go_q_free,
    output logic              err_multi
);
    logic [NUM_CMD-1:0] raw_cmd;
    logic [NUM_CMD-1:0] gated_cmd;
    logic [NUM_CMD-1:0] pulse_vec;
    logic               multi;
    seq_state_e         seq_state;

    cmdreg_field_decode #(
        .DATA_W  (DATA_W),
        .CMD_BASE(CMD_BASE),
        .NUM_CMD (NUM_CMD)
    ) u_dec (
        .wdata  (wdata),
        .cmd_vec(raw_cmd),
        .multi  (multi)
    );

    cmdreg_mode_gate #(
        .NUM_CMD(NUM_CMD),
        .ST_IDX (ST_IDX)
    ) u_gate (
        .cmd_in     (raw_cmd),
        .standby    (standby),
        .fresh_reset(fresh_reset),
        .cmd_out    (gated_cmd)
    );

    cmdreg_seq #(
        .NUM_CMD(NUM_CMD)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .cmd    (gated_cmd),
        .multi  (multi),
        .pulse_q(pulse_vec),
        .err_q  (err_multi),
        .state_q(seq_state)
    );

    assign rdata        = '0;
    assign go_proc_wr   = pulse_vec[0];
    assign go_proc_rd   = pulse_vec[1];
    assign go_selftest  = pulse_vec[2];
    assign go_color_clr = pulse_vec[3];
    assign go_row_wr    = pulse_vec[4];
    assign go_row_rd    = pulse_vec[5];
    assign go_ctl_tx    = pulse_vec[6];
    assign go_q_load    = pulse_vec[7];
    assign go_q_free    = pulse_vec[8];
endmodule

// File: rtl/cmdreg_checker.sv
module cmdreg_checker
    import cmdreg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wdata,
    input logic               standby,
    input logic               fresh_reset,
    input logic [NUM_CMD-1:0] pulse_vec,
    input logic               err_multi,
    input seq_state_e         seq_state
);
    localparam int CMD_MSB = DATA_W - 1 - CMD_BASE;

    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_vec) |-> $past(wr_en)); // R1
    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_vec)); // R1
    AST_NO_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (pulse_vec == '0)); // R1
    AST_RSVD_ONLY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[CMD_MSB:0] == '0 && wdata[DATA_W-1:CMD_MSB+1] != '0)
        |=> (pulse_vec == '0)); // R3
    AST_MULTI_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $countones(wdata[CMD_MSB:0]) > 1) |=> (pulse_vec == '0 && err_multi)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_multi |=> err_multi); // R4
    AST_SELFTEST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_vec[ST_IDX] |-> $past(standby && fresh_reset)); // R5
    AST_FIRE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_vec) |-> (seq_state == ST_FIRE)); // R8
endmodule

bind cmd_pulse_dispatch cmdreg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .standby    (standby),
    .fresh_reset(fresh_reset),
    .pulse_vec  (pulse_vec),
    .err_multi  (err_multi),
    .seq_state  (seq_state)
);

// File: tb/tb_cmd_pulse_dispatch.sv
`timescale 1ns/1ps
module tb_cmd_pulse_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        standby = 1'b0;
    logic        fresh_reset = 1'b0;
    logic go_proc_wr, go_proc_rd, go_selftest, go_color_clr, go_row_wr;
    logic go_row_rd, go_ctl_tx, go_q_load, go_q_free, err_multi;

    int total = 0;
    int bad = 0;
    logic exp_err = 1'b0;

    always #5 clk = ~clk;

    cmd_pulse_dispatch dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .standby(standby), .fresh_reset(fresh_reset),
        .go_proc_wr(go_proc_wr), .go_proc_rd(go_proc_rd), .go_selftest(go_selftest),
        .go_color_clr(go_color_clr), .go_row_wr(go_row_wr), .go_row_rd(go_row_rd),
        .go_ctl_tx(go_ctl_tx), .go_q_load(go_q_load), .go_q_free(go_q_free),
        .err_multi(err_multi)
    );

    // strobes arranged so that index i corresponds to wdata[i]
    function automatic logic [8:0] seen();
        return {go_proc_wr, go_proc_rd, go_selftest, go_color_clr, go_row_wr,
                go_row_rd, go_ctl_tx, go_q_load, go_q_free};
    endfunction

    function automatic logic [8:0] model(logic w, logic [15:0] d, logic sb, logic fr);
        logic [8:0] f;
        f = d[8:0];
        if (!w) return '0;
        if ($countones(f) > 1) return '0;
        if (f[6] && !(sb && fr)) return '0;
        return f;
    endfunction

    task automatic check(string tag, logic [8:0] exp_p);
        total++;
        if (seen() !== exp_p) begin
            bad++;
            $display("FAIL %s strobes actual=%b expected=%b", tag, seen(), exp_p);
        end
        total++;
        if (err_multi !== exp_err) begin
            bad++;
            $display("FAIL %s err_multi actual=%b expected=%b", tag, err_multi, exp_err);
        end
    endtask

    // drive at negedge, check one cycle later at negedge
    task automatic step(string tag, logic w, logic [15:0] d, logic sb, logic fr);
        logic [8:0] e;
        wr_en = w; wdata = d; standby = sb; fresh_reset = fr;
        e = model(w, d, sb, fr);
        if (w && $countones(d[8:0]) > 1) exp_err = 1'b1;
        @(negedge clk);
        check(tag, e);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R6 reset", '0);
        total++;
        if (rdata !== 16'h0) begin
            bad++; $display("FAIL R7 rdata actual=%h expected=0000", rdata);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 after release", '0);

        // R2 walking single command, then R1 idle cycle after each
        for (int i = 0; i < 9; i++) begin
            step("R2 single cmd", 1'b1, 16'(1) << i, 1'b1, 1'b1);
            step("R1 strobe one cycle", 1'b0, 16'h0, 1'b1, 1'b1);
        end
        // R3 reserved only / reserved plus command
        step("R3 reserved only", 1'b1, 16'hFE00, 1'b1, 1'b1);
        step("R3 reserved plus row write", 1'b1, 16'hFE10, 1'b1, 1'b1);
        // R5 self-test gating
        step("R5 selftest no standby", 1'b1, 16'h0040, 1'b0, 1'b1);
        step("R5 selftest not fresh", 1'b1, 16'h0040, 1'b1, 1'b0);
        step("R5 selftest neither", 1'b1, 16'h0040, 1'b0, 1'b0);
        step("R5 selftest legal", 1'b1, 16'h0040, 1'b1, 1'b1);
        // R8 back-to-back
        step("R8 back to back a", 1'b1, 16'h0001, 1'b0, 1'b0);
        step("R8 back to back b", 1'b1, 16'h0002, 1'b0, 1'b0);
        step("R8 back to back c", 1'b1, 16'h0002, 1'b0, 1'b0);
        step("R8 idle", 1'b0, 16'h0002, 1'b0, 1'b0);
        // R4 multi reject, including illegal selftest paired with another
        step("R4 selftest pair", 1'b1, 16'h0041, 1'b0, 1'b0);
        step("R4 sticky after idle", 1'b0, 16'h0, 1'b0, 1'b0);
        step("R4 valid after error", 1'b1, 16'h0100, 1'b0, 1'b0);

        // random mix, R1 R2 R3 R4 R5
        for (int n = 0; n < 400; n++) begin
            logic [15:0] d;
            int kind;
            kind = int'($urandom % 4);
            d = 16'($urandom) & 16'hFE00;
            if (kind == 0) d[8:0] = 9'(1) << ($urandom % 9);
            else if (kind == 1) d[8:0] = 9'($urandom);
            else if (kind == 2) d[8:0] = 9'h040;
            step("R1 random", ($urandom % 5) != 0, d, 1'(($urandom)), 1'(($urandom)));
        end

        total++;
        if (rdata !== 16'h0) begin
            bad++; $display("FAIL R7 rdata actual=%h expected=0000", rdata);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule